// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives one chip-select region of an external asynchronous memory. An internal requester offers one read or one write at a time on a request/acknowledge port. The sequencer then steps the memory lines through three timed phases: setup, strobe and hold. Each phase length comes from a 32-bit configuration word, and reads and writes have their own lengths. The configuration word also picks the device bus width (8 or 16 bits), the chip-select style and the minimum idle gap that must pass when the transfer direction flips.

The state machine has five states. IDLE waits for a request. TURN inserts the direction-change gap. SETUP drives the address, and for writes the data as well. STROBE pulses the output-enable or the write-enable. HOLD keeps the address and data steady after the strobe. The transitions are:
- IDLE→TURN is taken on a request whose direction differs from the previous access.
- IDLE→SETUP is taken on a request in the same direction as the previous access, or on the first request after reset.
- TURN→SETUP, SETUP→STROBE and STROBE→HOLD are each taken when the phase counter reaches zero.
- HOLD→IDLE is taken when the hold counter reaches zero. The acknowledge is asserted in that last hold cycle.

The configuration register may be rewritten at any time. An access copies the register when it is accepted and keeps that copy until it ends.

Top module: `amem_strobe_seq`

## Requirements
- R1: After reset the configuration word is 0x3FFFFFFC. As a result, a read asserts chip select for 88 cycles (16 setup, 64 strobe, 8 hold). After reset, `cfg_err` and `req_ack` are 0 and `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1.
- R2: Each phase lasts its field value plus one cycle. The write fields are setup [29:26], strobe [25:20] and hold [19:17]. The read fields are setup [16:13], strobe [12:7] and hold [6:4].
- R3: `mem_oe_n` is low only during the strobe phase of a read, and `mem_we_n` is low only during the strobe phase of a write. The two are never low together.
- R4: When bit 31 is 0, `mem_cs_n` stays low from the first setup cycle through the last hold cycle.
- R5: When bit 31 is 1, `mem_cs_n` is low only during the strobe phase.
- R6: Read data is captured from `mem_din` on the last strobe cycle and appears on `rsp_rdata`. `req_ack` is high for exactly one cycle: the last hold cycle.
- R7: When an access runs in the opposite direction to the one before it, TURN lasts turnaround field [3:2] plus one cycle. An access in the same direction starts after a single IDLE cycle, with no TURN.
- R8: Width code [1:0] = 0 selects an 8-bit bus. On an 8-bit bus, `mem_dout[15:8]` is driven 0 and `rsp_rdata[15:8]` reads 0. Code 1 selects a 16-bit bus. Codes 2 and 3 also act as a 16-bit bus, and writing either one sets `cfg_err`.
- R9: A configuration write made while an access is running does not change that access. The next access accepted uses the new word.
- R10: Bit 30 has no effect on timing. Writing it as 1 sets `cfg_err`, which then stays set until reset.
- R11: From setup through hold, `mem_addr` carries the request address. `mem_dout_en` is high during a write and low during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | Request completed (last hold cycle) |
| rsp_rdata | output | DATA_W | Captured read data |
| cfg_err | output | 1 | Sticky configuration error |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | DATA_W | External write data |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | DATA_W | External read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
A phase counter loaded with the wrong value, or a state that leaves too early, shows up in the first access it touches. The strobe count and the chip-select count come out wrong, so the acknowledge arrives a cycle early or late, or a late read capture returns zero data. A wrong direction memory or a stale configuration copy does not show inside the access itself. It shows as a wrong gap between one strobe and the next, so the bench times that gap on every back-to-back pair. A lost error flag is seen on the next cycle after the offending write.

// File: rtl/amem_pkg.sv
package amem_pkg;
    localparam int CFG_W  = 32;
    localparam int TIM_W  = 30;
    localparam int CNT_W  = 6;
    localparam int SS_POS = 31;
    localparam int EW_POS = 30;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h3FFF_FFFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic             sel_strobe;
        logic             wide;
        logic [CNT_W-1:0] setup_len;
        logic [CNT_W-1:0] strobe_len;
        logic [CNT_W-1:0] hold_len;
        logic [CNT_W-1:0] turn_len;
    } phase_cfg_t;
endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
    import amem_pkg::*;
(
    input  logic             sel_strobe,
    input  logic [TIM_W-1:0] timing,
    input  logic             is_write,
    output phase_cfg_t       pcfg
);
    always_comb begin
        pcfg.sel_strobe = sel_strobe;
        pcfg.wide       = |timing[1:0];
        pcfg.turn_len   = CNT_W'(timing[3:2]);
        if (is_write) begin
            pcfg.setup_len  = CNT_W'(timing[29:26]);
            pcfg.strobe_len = CNT_W'(timing[25:20]);
            pcfg.hold_len   = CNT_W'(timing[19:17]);
        end else begin
            pcfg.setup_len  = CNT_W'(timing[16:13]);
            pcfg.strobe_len = CNT_W'(timing[12:7]);
            pcfg.hold_len   = CNT_W'(timing[6:4]);
        end
    end
endmodule

// File: rtl/amem_phase_ctr.sv
module amem_phase_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
    import amem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int LANE_W = DATA_W / 2;

    seq_state_e        state_q, state_d;
    logic              cfg_ss_q;
    logic [TIM_W-1:0]  cfg_tim_q;
    logic              cfg_err_q;
    logic              act_ss_q, act_write_q;
    logic [TIM_W-1:0]  act_tim_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              have_prev_q, last_write_q;
    logic              accept, dir_flip, phase_done, active;
    logic              dec_ss, dec_write;
    logic [TIM_W-1:0]  dec_tim;
    phase_cfg_t        pcfg;
    logic              ctr_load;
    logic [CNT_W-1:0]  ctr_val;

    // configuration register; the extended-wait bit is never stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ss_q  <= CFG_RESET[SS_POS];
            cfg_tim_q <= CFG_RESET[TIM_W-1:0];
            cfg_err_q <= 1'b0;
        end else if (cfg_we) begin
            cfg_ss_q  <= cfg_wdata[SS_POS];
            cfg_tim_q <= cfg_wdata[TIM_W-1:0];
            cfg_err_q <= cfg_err_q | cfg_wdata[EW_POS] | cfg_wdata[1];
        end
    end

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign dir_flip = have_prev_q && (last_write_q != req_write);

    // idle decodes the live register for the new request; otherwise the snapshot
    assign dec_ss    = (state_q == ST_IDLE) ? cfg_ss_q  : act_ss_q;
    assign dec_tim   = (state_q == ST_IDLE) ? cfg_tim_q : act_tim_q;
    assign dec_write = (state_q == ST_IDLE) ? req_write : act_write_q;

    amem_cfg_decode u_dec (
        .sel_strobe (dec_ss),
        .timing     (dec_tim),
        .is_write   (dec_write),
        .pcfg       (pcfg)
    );

    amem_phase_ctr #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .zero     (phase_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and counter loads
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    ctr_load = 1'b1;
                    if (dir_flip) begin
                        state_d = ST_TURN;
                        ctr_val = pcfg.turn_len;
                    end else begin
                        state_d = ST_SETUP;
                        ctr_val = pcfg.setup_len;
                    end
                end
            end
            ST_TURN: begin
                if (phase_done) begin
                    state_d  = ST_SETUP;
                    ctr_load = 1'b1;
                    ctr_val  = pcfg.setup_len;
                end
            end
            ST_SETUP: begin
                if (phase_done) begin
                    state_d  = ST_STROBE;
                    ctr_load = 1'b1;
                    ctr_val  = pcfg.strobe_len;
                end
            end
            ST_STROBE: begin
                if (phase_done) begin
                    state_d  = ST_HOLD;
                    ctr_load = 1'b1;
                    ctr_val  = pcfg.hold_len;
                end
            end
            ST_HOLD: begin
                if (phase_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request snapshot, read capture and direction memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ss_q     <= 1'b0;
            act_write_q  <= 1'b0;
            act_tim_q    <= '0;
            addr_q       <= '0;
            wdata_q      <= '0;
            rdata_q      <= '0;
            have_prev_q  <= 1'b0;
            last_write_q <= 1'b0;
        end else begin
            if (accept) begin
                act_ss_q    <= cfg_ss_q;
                act_tim_q   <= cfg_tim_q;
                act_write_q <= req_write;
                addr_q      <= req_addr;
                wdata_q     <= req_wdata;
            end
            if (state_q == ST_STROBE && phase_done && !act_write_q)
                rdata_q <= pcfg.wide ? mem_din
                                     : {{(DATA_W-LANE_W){1'b0}}, mem_din[LANE_W-1:0]};
            if (state_q == ST_HOLD && phase_done) begin
                have_prev_q  <= 1'b1;
                last_write_q <= act_write_q;
            end
        end
    end

    // outputs
    always_comb begin
        active      = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        mem_cs_n    = pcfg.sel_strobe ? (state_q != ST_STROBE) : !active;
        mem_oe_n    = !((state_q == ST_STROBE) && !act_write_q);
        mem_we_n    = !((state_q == ST_STROBE) && act_write_q);
        mem_addr    = active ? addr_q : '0;
        mem_dout_en = active && act_write_q;
        if (!mem_dout_en)
            mem_dout = '0;
        else if (pcfg.wide)
            mem_dout = wdata_q;
        else
            mem_dout = {{(DATA_W-LANE_W){1'b0}}, wdata_q[LANE_W-1:0]};
        req_ack     = (state_q == ST_HOLD) && phase_done;
        rsp_rdata   = rdata_q;
        cfg_err     = cfg_err_q;
    end
endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ack,
    input logic cfg_err,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dout_en
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R4
    cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R11
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dout_en);

    // R11
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en);
endmodule

bind amem_strobe_seq amem_strobe_seq_chk u_chk (.*);

// File: tb/amem_strobe_seq_tb.sv
module amem_strobe_seq_tb;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct {
        bit          wr;
        bit          ss;
        logic [15:0] addr;
        logic [15:0] data;
        int          cs;
        int          stb;
        int          gap;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic        cfg_err;
    logic [15:0] mem_addr;
    logic [15:0] mem_dout;
    logic        mem_dout_en;
    logic [15:0] mem_din;
    logic        mem_cs_n, mem_oe_n, mem_we_n;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];
    logic [31:0] sh_cfg = 32'h3FFF_FFFC;
    bit   have_prev = 1'b0;
    bit   last_wr = 1'b0;
    int   last_hold = 0;
    int   cs_cnt = 0, stb_cnt = 0, idle_run = 0, gap_seen = 0;
    logic [15:0] wseen = '0;

    always #2.5 clk = ~clk;

    // memory model: drives data only while the output enable is low
    assign mem_din = mem_oe_n ? 16'h0000 : (mem_addr ^ 16'hC3A5);

    amem_strobe_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .cfg_err(cfg_err), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit ss, bit ew, int ws, int wt, int wh,
                                       int rs, int rt, int rh, int ta, int asz);
        return {ss, ew, 4'(ws), 6'(wt), 3'(wh), 4'(rs), 6'(rt), 3'(rh), 2'(ta), 2'(asz)};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sh_cfg = 32'h3FFF_FFFC;
        have_prev = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wdata = w;
        cfg_we = 1'b1;
        sh_cfg = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: computes the expected item from the shadow configuration
    task automatic do_access(input bit wr, input logic [15:0] addr,
                             input logic [15:0] data, input bit chk_gap);
        exp_t it;
        int s, t, h, ta;
        bit wide;
        logic [15:0] rd;
        wide = (sh_cfg[1:0] != 2'd0);
        ta   = int'(sh_cfg[3:2]);
        if (wr) begin
            s = int'(sh_cfg[29:26]); t = int'(sh_cfg[25:20]); h = int'(sh_cfg[19:17]);
        end else begin
            s = int'(sh_cfg[16:13]); t = int'(sh_cfg[12:7]); h = int'(sh_cfg[6:4]);
        end
        rd = addr ^ 16'hC3A5;
        it.wr   = wr;
        it.ss   = sh_cfg[31];
        it.addr = addr;
        it.data = wr ? (wide ? data : {8'h00, data[7:0]}) : (wide ? rd : {8'h00, rd[7:0]});
        it.cs   = sh_cfg[31] ? (t + 1) : (s + t + h + 3);
        it.stb  = t + 1;
        it.gap  = (chk_gap && have_prev)
                  ? (last_hold + 1 + ((last_wr != wr) ? ta + 1 : 0) + s + 1) : -1;
        q.push_back(it);
        have_prev = 1'b1;
        last_wr   = wr;
        last_hold = h + 1;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = data;
        do @(negedge clk); while (!req_ack);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // monitor: times each access at the ports and compares with the queue
    always @(negedge clk) begin
        if (!rst_n) begin
            cs_cnt = 0; stb_cnt = 0; idle_run = 0; gap_seen = 0;
        end else begin
            if (!mem_cs_n) cs_cnt++;
            if (!mem_oe_n || !mem_we_n) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 strobe with no request", 1, 0);
                end else begin
                    if (stb_cnt == 0) begin
                        gap_seen = idle_run;
                        chk(mem_addr == q[0].addr, "R11 address", mem_addr, q[0].addr);
                        chk(mem_dout_en == q[0].wr, "R11 drive enable", mem_dout_en, q[0].wr);
                        chk(mem_we_n == !q[0].wr && mem_oe_n == q[0].wr, "R3 strobe line",
                            {mem_oe_n, mem_we_n}, {q[0].wr, !q[0].wr});
                    end
                end
                if (!mem_we_n) wseen = mem_dout;
                stb_cnt++;
                idle_run = 0;
            end else begin
                idle_run++;
            end
            if (req_ack) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected ack", 1, 0);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk(stb_cnt == it.stb, "R2 strobe cycles", stb_cnt, it.stb);
                    chk(cs_cnt == it.cs, it.ss ? "R5 select cycles" : "R4 select cycles",
                        cs_cnt, it.cs);
                    if (it.wr)
                        chk(wseen == it.data, "R8 write data", wseen, it.data);
                    else
                        chk(rsp_rdata == it.data, "R6 read data", rsp_rdata, it.data);
                    if (it.gap >= 0)
                        chk(gap_seen == it.gap, "R7 strobe gap", gap_seen, it.gap);
                end
                cs_cnt = 0;
                stb_cnt = 0;
            end
        end
    end

    initial begin
        do_reset();
        // R1 idle state after reset
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 idle lines",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!req_ack && !cfg_err, "R1 ack and error", {req_ack, cfg_err}, 2'b00);
        // R1 default timing: 16 + 64 + 8 cycles
        do_access(1'b0, 16'h0012, 16'h0000, 1'b0);

        // R2 R7 distinct read and write timings, turnaround 3 cycles
        write_cfg(mk(0, 0, 2, 3, 1, 1, 2, 0, 2, 1));
        chk(!cfg_err, "R10 no error on legal word", cfg_err, 0);
        do_access(1'b1, 16'h0100, 16'hBEEF, 1'b0);
        do_access(1'b1, 16'h0102, 16'h1234, 1'b1);
        do_access(1'b0, 16'h0100, 16'h0000, 1'b1);
        do_access(1'b0, 16'h0104, 16'h0000, 1'b1);
        do_access(1'b1, 16'h0106, 16'h5555, 1'b1);

        // R2 minimum lengths everywhere
        write_cfg(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        do_access(1'b0, 16'h0010, 16'h0000, 1'b0);
        do_access(1'b1, 16'h0011, 16'h7E81, 1'b1);
        do_access(1'b1, 16'h0012, 16'h00FF, 1'b1);
        do_access(1'b0, 16'h0013, 16'h0000, 1'b1);

        // R5 select-strobe style
        write_cfg(mk(1, 0, 1, 2, 1, 2, 3, 1, 1, 1));
        do_access(1'b1, 16'h0A00, 16'hCAFE, 1'b0);
        do_access(1'b0, 16'h0A02, 16'h0000, 1'b1);

        // R8 8-bit bus
        write_cfg(mk(0, 0, 1, 1, 1, 1, 1, 1, 0, 0));
        do_access(1'b1, 16'h0200, 16'hA1B2, 1'b0);
        do_access(1'b0, 16'h0203, 16'h0000, 1'b1);

        // R9 rewrite during an access
        write_cfg(mk(0, 0, 1, 9, 1, 1, 9, 1, 1, 1));
        fork
            do_access(1'b0, 16'h0300, 16'h0000, 1'b0);
            begin
                repeat (4) @(negedge clk);
                write_cfg(mk(0, 0, 0, 1, 0, 0, 1, 0, 0, 1));
            end
        join
        do_access(1'b0, 16'h0304, 16'h0000, 1'b0);

        // R8 reserved width codes act as 16-bit and flag an error
        write_cfg(mk(0, 0, 1, 1, 1, 1, 1, 1, 0, 2));
        chk(cfg_err, "R8 reserved width error", cfg_err, 1);
        do_access(1'b0, 16'h0400, 16'h0000, 1'b0);
        write_cfg(mk(0, 0, 1, 1, 1, 1, 1, 1, 0, 3));
        do_access(1'b1, 16'h0401, 16'h9876, 1'b0);

        // R10 extended-wait bit ignored, error sticky
        do_reset();
        chk(!cfg_err, "R10 error cleared by reset", cfg_err, 0);
        write_cfg(mk(0, 1, 1, 2, 1, 1, 2, 1, 0, 1));
        chk(cfg_err, "R10 error set", cfg_err, 1);
        do_access(1'b1, 16'h0500, 16'h4321, 1'b0);
        do_access(1'b0, 16'h0500, 16'h0000, 1'b1);
        write_cfg(mk(0, 0, 1, 2, 1, 1, 2, 1, 0, 1));
        chk(cfg_err, "R10 error sticky", cfg_err, 1);

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R6 all requests acknowledged", q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule